// File: doc/BRIEF.md
# Base-plus-delta cache line codec

This block packs a 32-byte cache line, seen as eight 32-bit words, into a short form. Word 0 is the anchor. Every word, including the anchor, is subtracted from it, and the line can be packed only if every such difference fits a signed byte. A packable line leaves as a 96-bit record: the anchor followed by eight one-byte offsets, 20 bytes shorter than the raw line. Any other line leaves untouched, with the packed flag clear. Packing needs only subtractors and a range test for each lane.

A separate unpack path takes a 96-bit record. It rebuilds the eight words in one step by adding each sign-extended offset to the anchor. The two paths are independent. Each path is a single combinational stage whose result is captured on its own valid strobe. A memory controller can therefore pack a line on write-back and unpack it on a read, and an unpacked line equals the line that was packed.

Top module: `bdc_line_codec`

## Requirements
- R1: The anchor is word 0, at line bits [31:0]. After every strobe, pack_data_o[31:0] equals that word, whether or not the line was packed.
- R2: A line is packable exactly when, for each word i, the difference (word i − word 0), taken modulo 2^32 as a signed 32-bit value, lies in −128..+127. Differences that wrap around 2^32 are therefore judged by their modular value.
- R3: For a packable line, pack_ok_o is 1. pack_data_o[32+8i +: 8] holds the low byte of (word i − word 0), and pack_data_o[255:96] is zero.
- R4: For a line that is not packable, pack_ok_o is 0 and pack_data_o equals the input line bit for bit.
- R5: The unpack path outputs word i at unpack_line_o[32i +: 32]. That word equals unpack_rec_i[31:0] plus the sign extension of unpack_rec_i[32+8i +: 8], modulo 2^32.
- R6: Feeding pack_data_o[95:0] of a packed line into the unpack path reproduces the original line exactly.
- R7: Each path's valid output is high in the cycle after a strobe and low otherwise. While its strobe is low, the data outputs hold their values.
- R8: During reset, and until reset release has passed the two-stage synchroniser, both valid outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pack_vld_i | input | 1 | Strobe: capture the packed form of pack_line_i |
| pack_line_i | input | 256 | Raw line, word i at bits [32i +: 32] |
| pack_vld_o | output | 1 | Packed result valid |
| pack_ok_o | output | 1 | 1 when the line was packed |
| pack_data_o | output | 256 | Packed record (low 96 bits) or raw line |
| unpack_vld_i | input | 1 | Strobe: capture the expansion of unpack_rec_i |
| unpack_rec_i | input | 96 | Anchor in [31:0], offset i in [32+8i +: 8] |
| unpack_vld_o | output | 1 | Unpacked result valid |
| unpack_line_o | output | 256 | Rebuilt line |

## Verification
The assertions assume that each strobe is a single-cycle qualifier, sampled at the same edge as its data, and that data is known whenever the strobe is high. They also assume the unpack path is only ever given well-formed records, so nothing is checked about offset 0 being zero. The bench drives every input at the falling edge, raises a strobe for one cycle at a time and drops it before the next edge. It keeps data known at all times. Stimulus mixes lines with offsets near the signed-byte limits, lines that wrap around 2^32, and lines with one far word.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int unsigned BDC_WORD_W  = 32;
  localparam int unsigned BDC_N_WORDS = 8;
  localparam int unsigned BDC_DELTA_W = 8;
endpackage

// File: rtl/bdc_lane.sv
module bdc_lane #(
  parameter int unsigned WORD_W  = bdc_pkg::BDC_WORD_W,
  parameter int unsigned DELTA_W = bdc_pkg::BDC_DELTA_W
) (
  input  logic [WORD_W-1:0]  base_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [DELTA_W-1:0] delta_o,
  output logic               fits_o
);
  localparam int unsigned TOP_W = WORD_W - DELTA_W + 1;

  logic [WORD_W-1:0] diff;
  logic [TOP_W-1:0]  top_bits;

  always_comb begin
    diff     = word_i - base_i;
    top_bits = diff[WORD_W-1:DELTA_W-1];
    // fits a signed byte when the sign bit and every bit above it agree
    fits_o   = (&top_bits) | (~|top_bits);
    delta_o  = diff[DELTA_W-1:0];
  end
endmodule

// File: rtl/bdc_pack.sv
module bdc_pack #(
  parameter int unsigned WORD_W  = bdc_pkg::BDC_WORD_W,
  parameter int unsigned N_WORDS = bdc_pkg::BDC_N_WORDS,
  parameter int unsigned DELTA_W = bdc_pkg::BDC_DELTA_W
) (
  input  logic [WORD_W*N_WORDS-1:0] line_i,
  output logic                      ok_o,
  output logic [WORD_W*N_WORDS-1:0] data_o
);
  localparam int unsigned LINE_W = WORD_W * N_WORDS;
  localparam int unsigned PACK_W = WORD_W + N_WORDS * DELTA_W;

  logic [DELTA_W-1:0] delta [N_WORDS];
  logic [N_WORDS-1:0] fits;
  logic [PACK_W-1:0]  rec;

  for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_lane
    bdc_lane #(.WORD_W(WORD_W), .DELTA_W(DELTA_W)) u_lane (
      .base_i (line_i[WORD_W-1:0]),
      .word_i (line_i[gi*WORD_W +: WORD_W]),
      .delta_o(delta[gi]),
      .fits_o (fits[gi])
    );
  end

  always_comb begin
    rec = '0;
    rec[WORD_W-1:0] = line_i[WORD_W-1:0];
    for (int i = 0; i < N_WORDS; i++) begin
      rec[WORD_W + i*DELTA_W +: DELTA_W] = delta[i];
    end
    ok_o   = &fits;
    data_o = ok_o ? {{(LINE_W-PACK_W){1'b0}}, rec} : line_i;
  end
endmodule

// File: rtl/bdc_unpack.sv
module bdc_unpack #(
  parameter int unsigned WORD_W  = bdc_pkg::BDC_WORD_W,
  parameter int unsigned N_WORDS = bdc_pkg::BDC_N_WORDS,
  parameter int unsigned DELTA_W = bdc_pkg::BDC_DELTA_W
) (
  input  logic [WORD_W+N_WORDS*DELTA_W-1:0] rec_i,
  output logic [WORD_W*N_WORDS-1:0]         line_o
);
  for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_add
    logic [DELTA_W-1:0] d;
    assign d = rec_i[WORD_W + gi*DELTA_W +: DELTA_W];
    assign line_o[gi*WORD_W +: WORD_W] =
      rec_i[WORD_W-1:0] + {{(WORD_W-DELTA_W){d[DELTA_W-1]}}, d};
  end
endmodule

// File: rtl/bdc_line_codec.sv
module bdc_line_codec #(
  parameter int unsigned WORD_W  = bdc_pkg::BDC_WORD_W,
  parameter int unsigned N_WORDS = bdc_pkg::BDC_N_WORDS,
  parameter int unsigned DELTA_W = bdc_pkg::BDC_DELTA_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pack_vld_i,
  input  logic [WORD_W*N_WORDS-1:0]         pack_line_i,
  output logic                              pack_vld_o,
  output logic                              pack_ok_o,
  output logic [WORD_W*N_WORDS-1:0]         pack_data_o,
  input  logic                              unpack_vld_i,
  input  logic [WORD_W+N_WORDS*DELTA_W-1:0] unpack_rec_i,
  output logic                              unpack_vld_o,
  output logic [WORD_W*N_WORDS-1:0]         unpack_line_o
);
  localparam int unsigned LINE_W = WORD_W * N_WORDS;
  localparam int unsigned PACK_W = WORD_W + N_WORDS * DELTA_W;

  // reset synchroniser: asserts at once, releases after two edges
  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  logic rst_sn;
  assign rst_sn = rst_s2_q;

  logic              ok_c;
  logic [LINE_W-1:0] data_c;
  logic [LINE_W-1:0] line_c;

  bdc_pack #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .DELTA_W(DELTA_W)) u_pack (
    .line_i(pack_line_i), .ok_o(ok_c), .data_o(data_c)
  );

  bdc_unpack #(.WORD_W(WORD_W), .N_WORDS(N_WORDS), .DELTA_W(DELTA_W)) u_unpack (
    .rec_i(unpack_rec_i), .line_o(line_c)
  );

  // next-state
  logic              p_vld_d, p_ok_d, u_vld_d;
  logic [LINE_W-1:0] p_data_d, u_line_d;
  always_comb begin
    p_vld_d  = pack_vld_i;
    p_ok_d   = pack_vld_i ? ok_c   : pack_ok_o;
    p_data_d = pack_vld_i ? data_c : pack_data_o;
    u_vld_d  = unpack_vld_i;
    u_line_d = unpack_vld_i ? line_c : unpack_line_o;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pack_vld_o    <= 1'b0;
      pack_ok_o     <= 1'b0;
      pack_data_o   <= '0;
      unpack_vld_o  <= 1'b0;
      unpack_line_o <= '0;
    end else begin
      pack_vld_o    <= p_vld_d;
      pack_ok_o     <= p_ok_d;
      pack_data_o   <= p_data_d;
      unpack_vld_o  <= u_vld_d;
      unpack_line_o <= u_line_d;
    end
  end

  // R7: valid tracks the strobe by one cycle
  assert_pack_vld_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    pack_vld_i |=> pack_vld_o);
  assert_pack_idle_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !pack_vld_i |=> !pack_vld_o);
  assert_unpack_vld_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    unpack_vld_i |=> unpack_vld_o);
  assert_pack_hold_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !pack_vld_i |=> ($stable(pack_data_o) && $stable(pack_ok_o)));
  assert_unpack_hold_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    !unpack_vld_i |=> $stable(unpack_line_o));
  // R1: anchor always leads the output
  assert_anchor_R1: assert property (@(posedge clk) disable iff (!rst_sn)
    pack_vld_i |=> pack_data_o[WORD_W-1:0] == $past(pack_line_i[WORD_W-1:0]));
  // R3: packed record is zero above its 96 bits, offset 0 is zero
  assert_pad_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (pack_vld_o && pack_ok_o) |->
      (pack_data_o[LINE_W-1:PACK_W] == '0 &&
       pack_data_o[WORD_W +: DELTA_W] == '0));
  // R4: an unpackable line passes through raw
  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (pack_vld_i && !ok_c) |=> (!pack_ok_o && pack_data_o == $past(pack_line_i)));
  // R5: a zero offset rebuilds the anchor in word 0
  assert_unpack_base_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (unpack_vld_i && unpack_rec_i[WORD_W +: DELTA_W] == '0) |=>
      unpack_line_o[WORD_W-1:0] == $past(unpack_rec_i[WORD_W-1:0]));
endmodule

// File: tb/bdc_line_codec_tb.sv
module bdc_line_codec_tb;
  localparam int LW = 256;
  localparam int RW = 96;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          pack_vld_i, unpack_vld_i;
  logic [LW-1:0] pack_line_i, unpack_line_o, pack_data_o;
  logic [RW-1:0] unpack_rec_i;
  logic          pack_vld_o, pack_ok_o, unpack_vld_o;

  bdc_line_codec u_dut (
    .clk(clk), .rst_n(rst_n),
    .pack_vld_i(pack_vld_i), .pack_line_i(pack_line_i),
    .pack_vld_o(pack_vld_o), .pack_ok_o(pack_ok_o), .pack_data_o(pack_data_o),
    .unpack_vld_i(unpack_vld_i), .unpack_rec_i(unpack_rec_i),
    .unpack_vld_o(unpack_vld_o), .unpack_line_o(unpack_line_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                     input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_ok(input logic [LW-1:0] ln);
    logic signed [31:0] d;
    for (int i = 0; i < 8; i++) begin
      d = $signed(ln[32*i +: 32] - ln[31:0]);
      if (d < -128 || d > 127) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [LW-1:0] ref_data(input logic [LW-1:0] ln);
    logic [LW-1:0] r;
    logic [31:0]   d;
    if (!ref_ok(ln)) return ln;
    r = '0;
    r[31:0] = ln[31:0];
    for (int i = 0; i < 8; i++) begin
      d = ln[32*i +: 32] - ln[31:0];
      r[32 + 8*i +: 8] = d[7:0];
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] ref_unpack(input logic [RW-1:0] rc);
    logic [LW-1:0] r;
    int signed     off;
    for (int i = 0; i < 8; i++) begin
      off = $signed(rc[32 + 8*i +: 8]);
      r[32*i +: 32] = rc[31:0] + off;
    end
    return r;
  endfunction

  // pack one line and check; returns the captured output
  task automatic do_pack(input logic [LW-1:0] ln, input string tag,
                         output logic [LW-1:0] got, output logic got_ok);
    @(negedge clk);
    pack_vld_i  = 1'b1;
    pack_line_i = ln;
    @(negedge clk);
    pack_vld_i  = 1'b0;
    got    = pack_data_o;
    got_ok = pack_ok_o;
    chk(pack_vld_o == 1'b1, {"R7 pack valid ", tag}, LW'(pack_vld_o), LW'(1));
    chk(pack_ok_o == ref_ok(ln), {"R2 packable ", tag}, LW'(pack_ok_o), LW'(ref_ok(ln)));
    chk(pack_data_o == ref_data(ln),
        ref_ok(ln) ? {"R3 record ", tag} : {"R4 raw ", tag}, pack_data_o, ref_data(ln));
    chk(pack_data_o[31:0] == ln[31:0], {"R1 anchor ", tag},
        LW'(pack_data_o[31:0]), LW'(ln[31:0]));
  endtask

  task automatic do_unpack(input logic [RW-1:0] rc, input logic [LW-1:0] exp,
                           input string req);
    @(negedge clk);
    unpack_vld_i = 1'b1;
    unpack_rec_i = rc;
    @(negedge clk);
    unpack_vld_i = 1'b0;
    chk(unpack_vld_o == 1'b1, "R7 unpack valid", LW'(unpack_vld_o), LW'(1));
    chk(unpack_line_o == exp, req, unpack_line_o, exp);
  endtask

  task automatic roundtrip(input logic [LW-1:0] ln, input string tag);
    logic [LW-1:0] g;
    logic          k;
    do_pack(ln, tag, g, k);
    if (k) do_unpack(g[RW-1:0], ln, {"R6 roundtrip ", tag});
  endtask

  function automatic logic [LW-1:0] flat(input logic [31:0] b, input int signed off7);
    logic [LW-1:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = b + i;
    r[32*7 +: 32] = b + off7;
    return r;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [LW-1:0] g, ln, held;
    logic          k;
    logic [31:0]   b;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    pack_vld_i = 1'b0; unpack_vld_i = 1'b0;
    pack_line_i = '0;  unpack_rec_i = '0;
    repeat (3) @(negedge clk);
    chk(!pack_vld_o && !unpack_vld_o, "R8 reset valids", LW'({pack_vld_o, unpack_vld_o}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pack_vld_o && !unpack_vld_o, "R8 sync release", LW'({pack_vld_o, unpack_vld_o}), '0);
    repeat (3) @(negedge clk);

    // directed corners
    roundtrip({8{32'h1234_5678}}, "equal words");
    roundtrip(flat(32'h1000_0000, 127), "+127 edge");
    roundtrip(flat(32'h1000_0000, -128), "-128 edge");
    roundtrip(flat(32'h1000_0000, 128), "+128 over");
    roundtrip(flat(32'h1000_0000, -129), "-129 over");
    roundtrip(flat(32'h7FFF_FFFF, 1), "signed wrap");
    roundtrip(flat(32'hFFFF_FFF0, 32'sh20), "modular wrap");
    roundtrip(flat(32'h0000_0000, -128), "zero anchor");
    ln = flat(32'hABCD_0000, 3);
    ln[32*3 +: 32] = 32'h0BCD_0000;
    roundtrip(ln, "one far word");

    // hold while idle
    do_pack(flat(32'h5555_0000, 9), "pre-hold", held, k);
    @(negedge clk);
    pack_line_i = {8{32'hDEAD_BEEF}};
    @(negedge clk);
    chk(pack_vld_o == 1'b0, "R7 idle valid", LW'(pack_vld_o), '0);
    chk(pack_data_o == held && pack_ok_o == k, "R7 hold data", pack_data_o, held);

    // direct unpack of hand-made records
    do_unpack({8'h80, 8'h7F, 8'hFF, 8'h01, 8'h00, 8'h10, 8'hF0, 8'h00, 32'h0000_0005},
              ref_unpack({8'h80, 8'h7F, 8'hFF, 8'h01, 8'h00, 8'h10, 8'hF0, 8'h00, 32'h0000_0005}),
              "R5 signed add");

    // constrained random
    for (int t = 0; t < 300; t++) begin
      b = $urandom;
      if (t % 4 == 0) b = 32'hFFFF_FF00 + $urandom_range(0, 255);
      for (int i = 0; i < 8; i++) begin
        int signed off;
        off = $signed($urandom_range(0, 255)) - 128;
        if ($urandom_range(0, 19) == 0) off = off + ((off < 0) ? -1 : 1);
        ln[32*i +: 32] = b + off;
      end
      ln[31:0] = b;
      if ($urandom_range(0, 9) == 0) ln[32*5 +: 32] = $urandom;
      roundtrip(ln, "random");
    end
    for (int t = 0; t < 40; t++) begin
      logic [RW-1:0] rc;
      rc = {$urandom, $urandom, $urandom};
      do_unpack(rc, ref_unpack(rc), "R5 random record");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule